// File: doc/BRIEF.md
# Ranked Interrupt Controller With Cascade

The block collects interrupt requests from two banks of programmable sources and from seven external request lines, ranks every active and unmasked request by a level (1 to 7) and a priority slot within that level, and presents the level of the winner to the processor as a registered 3-bit code. Level 7 is the most urgent and level 1 the least. A level of 0 means no request.

Each programmable source has its own level and priority register. Each level has nine slots. External line n always sits in the middle slot of level n. Programmable priorities 0 to 3 rank below it, and priorities 4 to 7 rank above it. The two banks are internal units of the same design. Unit 0 also owns the external lines, and unit 0 wins any tie of equal rank.

When the processor acknowledges a level, the controller answers the next cycle with a fixed 8-bit vector for the highest-ranked pending request at that level. No cycle goes to the peripheral. If nothing is pending at that level, the answer is the spurious vector.

Top module: `lpic_top`

## Requirements
- R1: After reset `ipl` is 0, every per-source mask bit is 1 and both mask-all bits are 1, so no request can raise `ipl` until software clears the masks.
- R2: `ipl` is registered and gives the highest level among all active, unmasked, enabled requests. It is 0 when there are none.
- R3: Rank is ordered by level first, then by slot. Priority p in 0..3 takes slot p, external line n takes slot 4 of level n, and priority p in 4..7 takes slot p+1.
- R4: Per-source mask bit i (1 = masked) covers source i of the selected unit. Writing `msk_data` with `msk_hi`=0 loads bits 31..0, and with `msk_hi`=1 it loads bits 63..32.
- R5: While a unit's mask-all bit is 1, none of its requests count, including the external lines in unit 0.
- R6: `ack_req` with `ack_lvl` gives `ack_valid` one cycle later, with `ack_vec` set to the vector of the highest-ranked pending request at exactly that level. Source i of unit u has vector 64 + 64*u + i, and external line n has vector 192 + n.
- R7: An acknowledge with no pending request at the asked level returns vector 24.
- R8: Between the units, unit 1 wins only with a strictly higher rank. On an equal rank, unit 0 wins.
- R9: Level-7 requests are edge-sensitive. A rising edge latches a pending flag that survives the request dropping, and the acknowledge that selects it clears it. Levels 1..6 are level-sensitive, so a dropped request stops counting at once.
- R10: A source programmed with level 0 is disabled and never requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req_a | input | NSRC | Request lines of unit 0 sources |
| src_req_b | input | NSRC | Request lines of unit 1 sources |
| irq_ext | input | 7 | External lines; bit k is line k+1 |
| cfg_we | input | 1 | Write level/priority of one source |
| cfg_sel | input | 1 | Unit chosen by cfg and mask writes |
| cfg_idx | input | IW | Source index for a cfg write |
| cfg_level | input | 3 | Level written (0 disables) |
| cfg_prio | input | 3 | Priority written |
| msk_we | input | 1 | Write one 32-bit mask word |
| msk_hi | input | 1 | 0 = bits 31..0, 1 = bits 63..32 |
| msk_data | input | 32 | Mask word data |
| mall_we | input | 1 | Write the mask-all bit |
| mall_data | input | 1 | Mask-all value |
| ack_req | input | 1 | Acknowledge strobe |
| ack_lvl | input | 3 | Level being acknowledged |
| ipl | output | 3 | Registered winning level |
| ack_valid | output | 1 | Vector valid, one cycle after ack_req |
| ack_vec | output | 8 | Returned vector |

## Verification
The embedded properties watch things that hold on every cycle. A set mask-all bit keeps a unit silent. A winning rank never carries level 0. A vector appears only right after a strobe and always falls in the user range or equals the spurious code. Equal ranks always hand the acknowledge to unit 0. A latched level-7 flag never clears unless an acknowledge or a reprogramming takes it away. The middle-slot placement of the external lines, mask words landing at the right bit positions, the vector numbering and the re-arm behaviour of the level-7 edges depend on programmed sequences. Only the bench scenarios show these, by comparing each returned vector against an expected queue.

// File: rtl/lpic_pkg.sv
package lpic_pkg;
  localparam int LVLW  = 3;
  localparam int SLOTW = 4;
  localparam int RANKW = LVLW + SLOTW;
  localparam logic [SLOTW-1:0] EXT_SLOT = 4'd4;
  localparam logic [7:0] SPUR_VEC = 8'd24;

  typedef logic [RANKW-1:0] rank_t;

  function automatic rank_t mk_rank(input logic [2:0] lvl, input logic [2:0] pri);
    logic [SLOTW-1:0] s;
    s = (pri < 3'd4) ? {1'b0, pri} : ({1'b0, pri} + 4'd1);
    return {lvl, s};
  endfunction
endpackage

// File: rtl/lpic_unit.sv
module lpic_unit
  import lpic_pkg::*;
#(
  parameter int NSRC    = 63,
  parameter bit HAS_EXT = 1'b1,
  parameter int VBASE   = 64,
  parameter int VEXT    = 192,
  localparam int IW     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req,
  input  logic [6:0]      ext,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [2:0]      cfg_level,
  input  logic [2:0]      cfg_prio,
  input  logic            msk_we,
  input  logic            msk_hi,
  input  logic [31:0]     msk_data,
  input  logic            mall_we,
  input  logic            mall_data,
  input  logic [2:0]      ack_lvl,
  input  logic            ack_take,
  output logic            best_valid,
  output rank_t           best_rank,
  output logic            hit_valid,
  output rank_t           hit_rank,
  output logic [7:0]      hit_vec
);
  logic [2:0]      lvl_q [NSRC];
  logic [2:0]      pri_q [NSRC];
  logic [NSRC-1:0] msk_q, req_q, pend7_q, act, clr;
  logic            mall_q;
  logic [6:0]      ext_q;
  logic            ext7_pend_q;
  logic [6:0]      ext_act;
  rank_t           rank_a [NSRC];
  logic [IW-1:0]   hit_idx;
  logic            hit_ext;

  // configuration and mask storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSRC; i++) begin
        lvl_q[i] <= '0;
        pri_q[i] <= '0;
      end
      msk_q  <= '1;
      mall_q <= 1'b1;
    end else begin
      if (cfg_we) begin
        lvl_q[cfg_idx] <= cfg_level;
        pri_q[cfg_idx] <= cfg_prio;
      end
      if (msk_we) begin
        for (int b = 0; b < 32; b++) begin
          if ((msk_hi ? b + 32 : b) < NSRC)
            msk_q[msk_hi ? b + 32 : b] <= msk_data[b];
        end
      end
      if (mall_we) mall_q <= mall_data;
    end
  end

  // level-7 edge latches
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q       <= '0;
      pend7_q     <= '0;
      ext_q       <= '0;
      ext7_pend_q <= 1'b0;
    end else begin
      req_q <= req;
      ext_q <= ext;
      for (int i = 0; i < NSRC; i++)
        pend7_q[i] <= (lvl_q[i] == 3'd7) &&
                      ((pend7_q[i] && !clr[i]) || (req[i] && !req_q[i]));
      ext7_pend_q <= HAS_EXT &&
                     ((ext7_pend_q && !(ack_take && hit_ext && ack_lvl == 3'd7)) ||
                      (ext[6] && !ext_q[6]));
    end
  end

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      rank_a[i] = mk_rank(lvl_q[i], pri_q[i]);
      act[i]    = (lvl_q[i] != 3'd0) && !msk_q[i] && !mall_q &&
                  ((lvl_q[i] == 3'd7) ? pend7_q[i] : req[i]);
      clr[i]    = ack_take && hit_valid && !hit_ext && (hit_idx == IW'(i));
    end
    for (int k = 0; k < 7; k++)
      ext_act[k] = HAS_EXT && !mall_q && ((k == 6) ? ext7_pend_q : ext[k]);
  end

  // ranking search: overall winner and winner at the acknowledged level
  always_comb begin
    best_valid = 1'b0;
    best_rank  = '0;
    hit_valid  = 1'b0;
    hit_rank   = '0;
    hit_idx    = '0;
    hit_ext    = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (act[i]) begin
        if (!best_valid || rank_a[i] > best_rank) begin
          best_valid = 1'b1;
          best_rank  = rank_a[i];
        end
        if (lvl_q[i] == ack_lvl && (!hit_valid || rank_a[i] > hit_rank)) begin
          hit_valid = 1'b1;
          hit_rank  = rank_a[i];
          hit_idx   = IW'(i);
          hit_ext   = 1'b0;
        end
      end
    end
    for (int k = 0; k < 7; k++) begin
      if (ext_act[k]) begin
        if (!best_valid || {3'(k + 1), EXT_SLOT} > best_rank) begin
          best_valid = 1'b1;
          best_rank  = {3'(k + 1), EXT_SLOT};
        end
        if (3'(k + 1) == ack_lvl && (!hit_valid || {3'(k + 1), EXT_SLOT} > hit_rank)) begin
          hit_valid = 1'b1;
          hit_rank  = {3'(k + 1), EXT_SLOT};
          hit_ext   = 1'b1;
        end
      end
    end
    hit_vec = hit_ext ? 8'(VEXT + int'(ack_lvl)) : 8'(VBASE + int'(hit_idx));
  end

  p_mall_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    mall_q |-> !best_valid);
  p_lvl_nonzero_r10: assert property (@(posedge clk) disable iff (rst)
    best_valid |-> (best_rank[RANKW-1 -: 3] != 3'd0));
  p_pend7_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(ack_take) && !$past(cfg_we)) |-> (($past(pend7_q) & ~pend7_q) == '0));
endmodule

// File: rtl/lpic_cascade.sv
module lpic_cascade
  import lpic_pkg::*;
(
  input  logic       v0,
  input  rank_t      r0,
  input  logic [7:0] vec0,
  input  logic       v1,
  input  rank_t      r1,
  input  logic [7:0] vec1,
  output logic       sel_valid,
  output rank_t      sel_rank,
  output logic [7:0] sel_vec,
  output logic       pick1
);
  always_comb begin
    pick1     = v1 && (!v0 || r1 > r0);
    sel_valid = v0 || v1;
    sel_rank  = pick1 ? r1 : r0;
    sel_vec   = pick1 ? vec1 : vec0;
  end
endmodule

// File: rtl/lpic_top.sv
module lpic_top
  import lpic_pkg::*;
#(
  parameter int NSRC  = 63,
  parameter int VBASE = 64,
  parameter int VEXT  = 192,
  localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_req_a,
  input  logic [NSRC-1:0] src_req_b,
  input  logic [6:0]      irq_ext,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [2:0]      cfg_level,
  input  logic [2:0]      cfg_prio,
  input  logic            msk_we,
  input  logic            msk_hi,
  input  logic [31:0]     msk_data,
  input  logic            mall_we,
  input  logic            mall_data,
  input  logic            ack_req,
  input  logic [2:0]      ack_lvl,
  output logic [2:0]      ipl,
  output logic            ack_valid,
  output logic [7:0]      ack_vec
);
  logic [1:0]      bv, hv, take;
  rank_t           br [2];
  rank_t           hr [2];
  logic [7:0]      hvec [2];
  logic [NSRC-1:0] reqs [2];
  logic            bsel_v, hsel_v, bpick1, hpick1;
  rank_t           bsel_r, hsel_r;
  logic [7:0]      bsel_vec, hsel_vec;

  assign reqs[0] = src_req_a;
  assign reqs[1] = src_req_b;
  assign take[0] = ack_req && hsel_v && !hpick1;
  assign take[1] = ack_req && hsel_v && hpick1;

  for (genvar u = 0; u < 2; u++) begin : g_unit
    lpic_unit #(
      .NSRC(NSRC), .HAS_EXT(u == 0), .VBASE(VBASE + 64 * u), .VEXT(VEXT)
    ) u_unit (
      .clk(clk), .rst(rst), .req(reqs[u]), .ext(irq_ext),
      .cfg_we(cfg_we && (cfg_sel == 1'(u))), .cfg_idx(cfg_idx),
      .cfg_level(cfg_level), .cfg_prio(cfg_prio),
      .msk_we(msk_we && (cfg_sel == 1'(u))), .msk_hi(msk_hi), .msk_data(msk_data),
      .mall_we(mall_we && (cfg_sel == 1'(u))), .mall_data(mall_data),
      .ack_lvl(ack_lvl), .ack_take(take[u]),
      .best_valid(bv[u]), .best_rank(br[u]),
      .hit_valid(hv[u]), .hit_rank(hr[u]), .hit_vec(hvec[u])
    );
  end

  lpic_cascade u_best (
    .v0(bv[0]), .r0(br[0]), .vec0(8'd0), .v1(bv[1]), .r1(br[1]), .vec1(8'd0),
    .sel_valid(bsel_v), .sel_rank(bsel_r), .sel_vec(bsel_vec), .pick1(bpick1)
  );
  lpic_cascade u_hit (
    .v0(hv[0]), .r0(hr[0]), .vec0(hvec[0]), .v1(hv[1]), .r1(hr[1]), .vec1(hvec[1]),
    .sel_valid(hsel_v), .sel_rank(hsel_r), .sel_vec(hsel_vec), .pick1(hpick1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ipl       <= '0;
      ack_valid <= 1'b0;
      ack_vec   <= '0;
    end else begin
      ipl       <= bsel_v ? bsel_r[RANKW-1 -: 3] : 3'd0;
      ack_valid <= ack_req;
      if (ack_req) ack_vec <= hsel_v ? hsel_vec : SPUR_VEC;
    end
  end

  p_ipl_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ipl == 3'd0));
  p_ack_follows_r6: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> $past(ack_req));
  p_vec_range_r7: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> (ack_vec == SPUR_VEC || ack_vec >= 8'd64));
  p_tie_unit0_r8: assert property (@(posedge clk) disable iff (rst)
    (ack_req && hv[0] && hv[1] && hr[0] == hr[1]) |=> (ack_vec == $past(hvec[0])));
  p_ipl_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!bv[0] && !bv[1]) |=> (ipl == 3'd0));
endmodule

// File: tb/sim_lpic_top.sv
module sim_lpic_top;
  localparam int NSRC = 63;
  localparam int IW   = $clog2(NSRC);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSRC-1:0] src_req_a = '0, src_req_b = '0;
  logic [6:0]  irq_ext = '0;
  logic        cfg_we = 0, cfg_sel = 0, msk_we = 0, msk_hi = 0, mall_we = 0, mall_data = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [2:0]  cfg_level = '0, cfg_prio = '0, ack_lvl = '0;
  logic [31:0] msk_data = '0;
  logic        ack_req = 0;
  logic [2:0]  ipl;
  logic        ack_valid;
  logic [7:0]  ack_vec;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  lpic_top #(.NSRC(NSRC)) u0 (
    .clk, .rst, .src_req_a, .src_req_b, .irq_ext, .cfg_we, .cfg_sel, .cfg_idx,
    .cfg_level, .cfg_prio, .msk_we, .msk_hi, .msk_data, .mall_we, .mall_data,
    .ack_req, .ack_lvl, .ipl, .ack_valid, .ack_vec
  );

  task automatic cfg(input bit u, input int idx, input int l, input int p);
    @(negedge clk);
    cfg_we = 1; cfg_sel = u; cfg_idx = IW'(idx); cfg_level = 3'(l); cfg_prio = 3'(p);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic mask(input bit u, input bit hi, input logic [31:0] d);
    @(negedge clk);
    msk_we = 1; cfg_sel = u; msk_hi = hi; msk_data = d;
    @(negedge clk);
    msk_we = 0;
  endtask

  task automatic mall(input bit u, input bit v);
    @(negedge clk);
    mall_we = 1; cfg_sel = u; mall_data = v;
    @(negedge clk);
    mall_we = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_ipl(input int e, input string tag);
    checks++;
    if (ipl !== 3'(e)) begin
      fails++;
      $display("FAIL %s ipl actual=%0d expected=%0d", tag, ipl, e);
    end
  endtask

  // driver: push expectation, pulse strobe
  task automatic do_ack(input int l, input int e, input string tag);
    @(negedge clk);
    exp_q.push_back(8'(e));
    tag_q.push_back(tag);
    ack_lvl = 3'(l); ack_req = 1;
    @(negedge clk);
    ack_req = 0;
    @(negedge clk);
  endtask

  // monitor: pop and compare
  always @(negedge clk) begin
    if (!rst && ack_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected vector actual=%0d expected=none", ack_vec);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (ack_vec !== e) begin
          fails++;
          $display("FAIL %s vector actual=%0d expected=%0d", t, ack_vec, e);
        end
      end
    end
  end

  task automatic quiet();
    @(negedge clk);
    src_req_a = '0; src_req_b = '0; irq_ext = '0;
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    settle();
    chk_ipl(0, "R1 reset");
    do_ack(1, 24, "R7 empty");
    cfg(0, 3, 3, 5);
    @(negedge clk); src_req_a[3] = 1;
    settle();
    chk_ipl(0, "R1 masked after reset");
    mask(0, 0, 32'h0); mask(0, 1, 32'h0); mall(0, 0);
    settle();
    chk_ipl(3, "R2 single");
    cfg(0, 5, 5, 0);
    @(negedge clk); src_req_a[5] = 1;
    settle();
    chk_ipl(5, "R2 higher level");
    do_ack(3, 67, "R6 level3");
    do_ack(5, 69, "R6 level5");
    do_ack(2, 24, "R7 none at level");
    quiet();
    // slot order within level 4
    cfg(0, 10, 4, 3); cfg(0, 11, 4, 4);
    @(negedge clk); src_req_a[10] = 1; irq_ext[3] = 1;
    settle();
    chk_ipl(4, "R2 level4");
    do_ack(4, 196, "R3 ext above prio3");
    @(negedge clk); src_req_a[11] = 1;
    do_ack(4, 75, "R3 prio4 above ext");
    mask(0, 0, 32'h0000_0800);
    do_ack(4, 196, "R4 low word bit11");
    cfg(0, 40, 2, 1);
    @(negedge clk); src_req_a[40] = 1;
    do_ack(2, 104, "R4 high source");
    mask(0, 1, 32'h0000_0100);
    do_ack(2, 24, "R4 high word bit8");
    mask(0, 0, 32'h0); mask(0, 1, 32'h0);
    mall(0, 1);
    settle();
    chk_ipl(0, "R5 mask-all");
    do_ack(4, 24, "R5 mask-all ack");
    mall(0, 0);
    quiet();
    cfg(0, 10, 0, 7);
    @(negedge clk); src_req_a[10] = 1;
    settle();
    chk_ipl(0, "R10 disabled");
    do_ack(0, 24, "R10 disabled ack");
    quiet();
    // cascade
    cfg(1, 3, 3, 5);
    mask(1, 0, 32'h0); mask(1, 1, 32'h0); mall(1, 0);
    @(negedge clk); src_req_a[3] = 1; src_req_b[3] = 1;
    settle();
    chk_ipl(3, "R8 both");
    do_ack(3, 67, "R8 tie to unit0");
    cfg(1, 4, 3, 6);
    @(negedge clk); src_req_b[4] = 1;
    do_ack(3, 132, "R8 unit1 higher");
    quiet();
    // level 7 edge and level sensitivity
    cfg(0, 20, 7, 0);
    @(negedge clk); src_req_a[20] = 1;
    @(negedge clk); src_req_a[20] = 0;
    settle();
    chk_ipl(7, "R9 latched edge");
    do_ack(7, 84, "R9 edge ack");
    settle();
    chk_ipl(0, "R9 cleared by ack");
    do_ack(7, 24, "R9 no re-fire");
    @(negedge clk); irq_ext[6] = 1;
    @(negedge clk); irq_ext[6] = 0;
    settle();
    do_ack(7, 199, "R9 ext7 edge");
    @(negedge clk); src_req_a[5] = 1;
    settle();
    chk_ipl(5, "R9 level5 held");
    @(negedge clk); src_req_a[5] = 0;
    settle();
    chk_ipl(0, "R9 level5 dropped");
    do_ack(5, 24, "R9 level-sensitive");
    settle();
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R6 missing vectors actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule